// File: doc/BRIEF.md
# MMU Access Fault Checker

This block decides whether one memory access may proceed, given the translation descriptors that a table walker hands it. It takes the access (virtual address, read or write, privileged or user, transfer size) together with the domain access control word and two protection-mode control bits. It inspects the first-level descriptor when that descriptor arrives, then the second-level descriptor if the first level points to a page table. It raises a one-cycle `done` pulse carrying either a clean grant or an abort with a 4-bit fault code and the domain involved.

The checks run in a fixed order:

1. Alignment.
2. First-level translation.
3. Domain.
4. Section permission, or second-level translation and then page permission.

The first check that refuses the access ends the evaluation. For large and small pages the second-level descriptor carries four access-permission fields, one for each quarter of the page. The quarter is picked from different virtual address bits depending on the page size.

The block does not walk tables, cache descriptors or form physical addresses. It only judges the descriptors that are presented to it.

Top module: `mmu_fault_check`

## Requirements
- R1: An access is misaligned when size 1 (halfword) has address bit 0 set, or size 2 or 3 (word) has address bits [1:0] non-zero. Size 0 (byte) is never misaligned. A misaligned access finishes on the edge that accepts the request, with fault code 0001 and domain 0, and it waits for no descriptor.
- R2: A first-level descriptor with bits [1:0] = 00 aborts with section translation code 0101 and domain 0.
- R3: First-level bits [8:5] hold a domain number d. Domain control bits [2d+1:2d] are checked on the edge the first-level descriptor is accepted. Value 00 or 10 aborts at once with code 1001 when first-level bits [1:0] = 10 (section), and with code 1011 when they are 01 or 11 (page table).
- R4: Domain value 11 grants the access with no permission check. For a section this happens on the first-level edge. For a page it happens on the second-level edge, provided second-level bits [1:0] are non-zero.
- R5: For a section under domain value 01, the permission field is first-level bits [11:10]. A refusal aborts with code 1101.
- R6: A second-level descriptor with bits [1:0] = 00 aborts with page translation code 0111.
- R7: Second-level permission field k (k = 0..3) sits at bits [5+2k:4+2k].
  - Type 01 (large page) picks k from address bits [15:14].
  - Type 10 (small page) picks k from address bits [11:10].
  - Type 11 (tiny page) always uses k = 0.
  - A refusal under domain value 01 aborts with code 1111.
- R8: Permission fields decode as follows:
  - 11 grants everything.
  - 10 grants privileged access and user reads.
  - 01 grants privileged access only.
  - 00 with control bits (S,R) = (0,0) or (1,1) grants nothing.
  - 00 with (1,0) grants privileged reads only.
  - 00 with (0,1) grants reads in both modes.
- R9: `done` is a one-cycle pulse per access. `abort` is high only together with `done`. A grant reports code 0000 and domain 0. Domain, permission and page translation faults report domain d.
- R10: A request is taken only when the block is idle. `reqValid` pulses while an access is in flight are ignored and produce no result.
- R11: After reset `done` and `abort` are 0 and the fault code is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request strobe |
| reqAddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPriv | input | 1 | 1 = privileged mode |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| l1Valid | input | 1 | First-level descriptor strobe |
| l1Desc | input | 32 | First-level descriptor |
| l2Valid | input | 1 | Second-level descriptor strobe |
| l2Desc | input | 32 | Second-level descriptor |
| domainCtl | input | 32 | Sixteen 2-bit domain entries |
| sysProt | input | 1 | S protection bit |
| romProt | input | 1 | R protection bit |
| done | output | 1 | Result pulse |
| abort | output | 1 | Access refused, valid with done |
| faultStatus | output | 4 | Fault code |
| faultDomain | output | 4 | Domain tied to the fault |

## Verification
Every size is paired with every address offset, which shows the alignment gate firing both before and instead of the descriptor checks. All four domain values are tried on both sections and page tables, which separates the section and page fault codes from the manager bypass. A sweep over all permission codes, protection-bit pairs, modes and directions pins down the permission decode. Large and small pages are given four distinct permission fields with the two candidate address quarters set to different values, so picking the wrong address bits or the wrong field order yields a wrong verdict.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;

  localparam int DOM_CNT = 16;
  localparam int DOM_W   = $clog2(DOM_CNT);
  localparam int AP_CNT  = 4;
  localparam int AP_LSB  = 4;

  typedef enum logic [3:0] {
    FS_NONE      = 4'b0000,
    FS_ALIGN     = 4'b0001,
    FS_XLAT_SEC  = 4'b0101,
    FS_XLAT_PAGE = 4'b0111,
    FS_DOM_SEC   = 4'b1001,
    FS_DOM_PAGE  = 4'b1011,
    FS_PERM_SEC  = 4'b1101,
    FS_PERM_PAGE = 4'b1111
  } faultCode_e;

  typedef struct packed {
    logic capReq;
    logic capL1;
    logic finAlign;
    logic finL1;
    logic finL2;
  } ctrlStrobe_t;

  // permission decode; S/R only matter for field value 00
  function automatic logic apGrant(input logic [1:0] ap, input logic priv,
                                   input logic write, input logic sBit,
                                   input logic rBit);
    logic ok;
    unique case (ap)
      2'b11: ok = 1'b1;
      2'b10: ok = priv | ~write;
      2'b01: ok = priv;
      default: begin
        unique case ({sBit, rBit})
          2'b10:   ok = priv & ~write;
          2'b01:   ok = ~write;
          default: ok = 1'b0;
        endcase
      end
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/mmu_fault_dp.sv
module mmu_fault_dp
  import mmu_fault_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [AW-1:0]        reqAddr,
  input  logic                 reqWrite,
  input  logic                 reqPriv,
  input  logic [1:0]           reqSize,
  input  logic [DW-1:0]        l1Desc,
  input  logic [DW-1:0]        l2Desc,
  input  logic [2*DOM_CNT-1:0] domainCtl,
  input  logic                 sysProt,
  input  logic                 romProt,
  output logic                 misaligned,
  output logic                 l1Final,
  output logic [1:0]           heldDomVal,
  output logic                 doneOut,
  output logic                 abortOut,
  output logic [3:0]           statusOut,
  output logic [DOM_W-1:0]     domainOut
);

  // captured request and first-level results
  logic [5:0]       addrQ;    // address bits [15:10]
  logic             writeQ, privQ;
  logic [DOM_W-1:0] domNumQ;
  logic [1:0]       domValQ;

  logic unusedAddr;
  assign unusedAddr = ^{reqAddr[AW-1:16], reqAddr[9:2]};
  logic unusedDesc;
  assign unusedDesc = ^{l1Desc[DW-1:12], l1Desc[9], l1Desc[4:2],
                        l2Desc[DW-1:AP_LSB+2*AP_CNT], l2Desc[AP_LSB-1:2]};

  // alignment gate
  always_comb begin
    unique case (reqSize)
      2'd0:    misaligned = 1'b0;
      2'd1:    misaligned = reqAddr[0];
      default: misaligned = |reqAddr[1:0];
    endcase
  end

  // first-level evaluation
  logic [1:0]       l1Type;
  logic [DOM_W-1:0] domNum;
  logic [1:0]       domVal;
  logic             isSection;
  faultCode_e       l1Code;

  assign l1Type    = l1Desc[1:0];
  assign domNum    = l1Desc[8:5];
  assign domVal    = domainCtl[{domNum, 1'b0} +: 2];
  assign isSection = (l1Type == 2'b10);

  always_comb begin
    if (l1Type == 2'b00)
      l1Code = FS_XLAT_SEC;
    else if (!domVal[0])
      l1Code = isSection ? FS_DOM_SEC : FS_DOM_PAGE;
    else if (isSection && domVal == 2'b01 &&
             !apGrant(l1Desc[11:10], privQ, writeQ, sysProt, romProt))
      l1Code = FS_PERM_SEC;
    else
      l1Code = FS_NONE;
  end

  assign l1Final = (l1Type == 2'b00) || !domVal[0] || isSection;

  // second-level evaluation: four permission fields, one per quarter
  logic [1:0] apFld [AP_CNT];
  for (genvar k = 0; k < AP_CNT; k++) begin : gApFld
    assign apFld[k] = l2Desc[AP_LSB+2*k +: 2];
  end

  logic [1:0] l2Type;
  logic [1:0] quarter;
  faultCode_e l2Code;

  assign l2Type = l2Desc[1:0];

  always_comb begin
    unique case (l2Type)
      2'b01:   quarter = addrQ[5:4];  // large page: bits [15:14]
      2'b10:   quarter = addrQ[1:0];  // small page: bits [11:10]
      default: quarter = 2'b00;
    endcase
  end

  always_comb begin
    if (l2Type == 2'b00)
      l2Code = FS_XLAT_PAGE;
    else if (domValQ == 2'b11)
      l2Code = FS_NONE;
    else if (!apGrant(apFld[quarter], privQ, writeQ, sysProt, romProt))
      l2Code = FS_PERM_PAGE;
    else
      l2Code = FS_NONE;
  end

  // captured state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      writeQ  <= 1'b0;
      privQ   <= 1'b0;
      domNumQ <= '0;
      domValQ <= 2'b00;
    end else begin
      if (strobe.capReq) begin
        addrQ  <= reqAddr[15:10];
        writeQ <= reqWrite;
        privQ  <= reqPriv;
      end
      if (strobe.capL1) begin
        domNumQ <= domNum;
        domValQ <= domVal;
      end
    end
  end

  assign heldDomVal = domValQ;

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneOut   <= 1'b0;
      abortOut  <= 1'b0;
      statusOut <= FS_NONE;
      domainOut <= '0;
    end else begin
      doneOut   <= strobe.finAlign | strobe.finL1 | strobe.finL2;
      abortOut  <= 1'b0;
      statusOut <= FS_NONE;
      domainOut <= '0;
      if (strobe.finAlign) begin
        abortOut  <= 1'b1;
        statusOut <= FS_ALIGN;
      end else if (strobe.finL1) begin
        abortOut  <= (l1Code != FS_NONE);
        statusOut <= l1Code;
        domainOut <= (l1Code == FS_NONE || l1Code == FS_XLAT_SEC) ? '0 : domNum;
      end else if (strobe.finL2) begin
        abortOut  <= (l2Code != FS_NONE);
        statusOut <= l2Code;
        domainOut <= (l2Code == FS_NONE) ? '0 : domNumQ;
      end
    end
  end

  AST_ABORT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |-> doneOut); // R9
  AST_GRANT_ZERO_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !abortOut) |-> (statusOut == 4'b0000 && domainOut == '0)); // R9
  AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finAlign |=> (statusOut == 4'b0001 && abortOut)); // R1
  AST_XLAT_SEC_NO_DOM: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && statusOut == 4'b0101) |-> (domainOut == '0)); // R2

endmodule

// File: rtl/mmu_fault_ctrl.sv
module mmu_fault_ctrl
  import mmu_fault_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        l1Valid,
  input  logic        l2Valid,
  input  logic        misaligned,
  input  logic        l1Final,
  input  logic [1:0]  heldDomVal,
  output ctrlStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_L1, ST_WAIT_L2} state_e;
  state_e state, stateNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.capReq = 1'b1;
        if (misaligned) strobe.finAlign = 1'b1;
        else            stateNxt = ST_WAIT_L1;
      end
      ST_WAIT_L1: if (l1Valid) begin
        strobe.capL1 = 1'b1;
        if (l1Final) begin
          strobe.finL1 = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          stateNxt = ST_WAIT_L2;
        end
      end
      ST_WAIT_L2: if (l2Valid) begin
        strobe.finL2 = 1'b1;
        stateNxt     = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  AST_ONE_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.finAlign, strobe.finL1, strobe.finL2})); // R9
  AST_L2_ONLY_OPEN_DOMAIN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_L2) |-> heldDomVal[0]); // R3
  AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_L1 && !l1Valid && reqValid) |=> (state == ST_WAIT_L1)); // R10

endmodule

// File: rtl/mmu_fault_check.sv
module mmu_fault_check
  import mmu_fault_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [AW-1:0]        reqAddr,
  input  logic                 reqWrite,
  input  logic                 reqPriv,
  input  logic [1:0]           reqSize,
  input  logic                 l1Valid,
  input  logic [DW-1:0]        l1Desc,
  input  logic                 l2Valid,
  input  logic [DW-1:0]        l2Desc,
  input  logic [2*DOM_CNT-1:0] domainCtl,
  input  logic                 sysProt,
  input  logic                 romProt,
  output logic                 done,
  output logic                 abort,
  output logic [3:0]           faultStatus,
  output logic [DOM_W-1:0]     faultDomain
);

  ctrlStrobe_t strobe;
  logic        misaligned, l1Final;
  logic [1:0]  heldDomVal;

  mmu_fault_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .l1Valid    (l1Valid),
    .l2Valid    (l2Valid),
    .misaligned (misaligned),
    .l1Final    (l1Final),
    .heldDomVal (heldDomVal),
    .strobe     (strobe)
  );

  mmu_fault_dp #(.AW(AW), .DW(DW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .reqPriv    (reqPriv),
    .reqSize    (reqSize),
    .l1Desc     (l1Desc),
    .l2Desc     (l2Desc),
    .domainCtl  (domainCtl),
    .sysProt    (sysProt),
    .romProt    (romProt),
    .misaligned (misaligned),
    .l1Final    (l1Final),
    .heldDomVal (heldDomVal),
    .doneOut    (done),
    .abortOut   (abort),
    .statusOut  (faultStatus),
    .domainOut  (faultDomain)
  );

endmodule

// File: tb/sim_mmu_fault_check.sv
module sim_mmu_fault_check;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0, reqPriv = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic        l1Valid = 1'b0, l2Valid = 1'b0;
  logic [31:0] l1Desc = '0, l2Desc = '0;
  logic [31:0] domainCtl = '0;
  logic        sysProt = 1'b0, romProt = 1'b0;
  logic        done, abort;
  logic [3:0]  faultStatus, faultDomain;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  mmu_fault_check u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqPriv(reqPriv), .reqSize(reqSize),
    .l1Valid(l1Valid), .l1Desc(l1Desc), .l2Valid(l2Valid), .l2Desc(l2Desc),
    .domainCtl(domainCtl), .sysProt(sysProt), .romProt(romProt),
    .done(done), .abort(abort), .faultStatus(faultStatus),
    .faultDomain(faultDomain)
  );

  typedef struct {
    logic       ab;
    logic [3:0] st;
    logic [3:0] dm;
    string      tag;
  } exp_t;

  exp_t expQ[$];

  function automatic logic permOk(logic [1:0] ap, logic pv, logic wr,
                                  logic s, logic r);
    if (ap == 2'b11) return 1'b1;
    if (ap == 2'b10) return pv || !wr;
    if (ap == 2'b01) return pv;
    if (s && !r) return pv && !wr;
    if (!s && r) return !wr;
    return 1'b0;
  endfunction

  function automatic logic [31:0] secDesc(logic [3:0] dom, logic [1:0] ap);
    return {20'h0, ap, 1'b0, dom, 3'b000, 2'b10};
  endfunction

  function automatic logic [31:0] tblDesc(logic [3:0] dom);
    return {23'h0, dom, 3'b000, 2'b01};
  endfunction

  function automatic logic [31:0] pgDesc(logic [1:0] ty, logic [7:0] aps);
    return {20'h0, aps, 2'b00, ty};
  endfunction

  // driver: model the expected result, queue it, then drive the handshake
  task automatic doAccess(logic [31:0] addr, logic wr, logic pv, logic [1:0] sz,
                          logic [31:0] d1, logic [31:0] d2, string tag);
    exp_t e;
    logic mis, needL1, needL2;
    logic [3:0] dom;
    logic [1:0] dv, q, ap;
    mis = (sz == 2'd1) ? addr[0] : (sz >= 2'd2) ? (addr[1:0] != 2'b00) : 1'b0;
    needL1 = 1'b0; needL2 = 1'b0;
    e.tag = tag; e.ab = 1'b0; e.st = 4'h0; e.dm = 4'h0;
    dom = d1[8:5];
    dv  = domainCtl[2*dom +: 2];
    if (mis) begin
      e.ab = 1'b1; e.st = 4'b0001;
    end else begin
      needL1 = 1'b1;
      if (d1[1:0] == 2'b00) begin
        e.ab = 1'b1; e.st = 4'b0101;
      end else if (dv == 2'b00 || dv == 2'b10) begin
        e.ab = 1'b1; e.dm = dom;
        e.st = (d1[1:0] == 2'b10) ? 4'b1001 : 4'b1011;
      end else if (d1[1:0] == 2'b10) begin
        if (dv == 2'b01 && !permOk(d1[11:10], pv, wr, sysProt, romProt)) begin
          e.ab = 1'b1; e.st = 4'b1101; e.dm = dom;
        end
      end else begin
        needL2 = 1'b1;
        if (d2[1:0] == 2'b00) begin
          e.ab = 1'b1; e.st = 4'b0111; e.dm = dom;
        end else if (dv == 2'b01) begin
          q  = (d2[1:0] == 2'b01) ? addr[15:14] :
               (d2[1:0] == 2'b10) ? addr[11:10] : 2'b00;
          ap = d2[4 + 2*q +: 2];
          if (!permOk(ap, pv, wr, sysProt, romProt)) begin
            e.ab = 1'b1; e.st = 4'b1111; e.dm = dom;
          end
        end
      end
    end
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqWrite = wr; reqPriv = pv; reqSize = sz;
    @(negedge clk);
    reqValid = 1'b0;
    if (needL1) begin
      l1Valid = 1'b1; l1Desc = d1;
      @(negedge clk);
      l1Valid = 1'b0;
    end
    if (needL2) begin
      l2Valid = 1'b1; l2Desc = d2;
      @(negedge clk);
      l2Valid = 1'b0;
    end
    @(negedge clk);
  endtask

  // monitor: compare every result pulse against the queue
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN && done) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected done: actual status %b expected none", faultStatus);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (abort !== e.ab || faultStatus !== e.st || faultDomain !== e.dm) begin
            errors++;
            $display("FAIL %s: actual ab=%b st=%b dm=%0d expected ab=%b st=%b dm=%0d",
                     e.tag, abort, faultStatus, faultDomain, e.ab, e.st, e.dm);
          end
        end
      end else if (rstN && abort) begin
        checks++; errors++;
        $display("FAIL R9 abort without done: actual 1 expected 0");
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R11
    if (done !== 1'b0 || abort !== 1'b0 || faultStatus !== 4'h0) begin
      errors++;
      $display("FAIL R11 reset: actual %b%b%b expected 000", done, abort, faultStatus);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R1: size/offset sweep with manager section in domain 0
    domainCtl = 32'h0000_0003;
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++)
        doAccess(32'h0000_1000 + off, 1'b1, 1'b0, sz[1:0],
                 secDesc(4'd0, 2'b00), '0, "R1");

    // R2: invalid first level, even with manager domain
    doAccess(32'h2000, 1'b0, 1'b1, 2'd2, 32'h0000_0000, '0, "R2");
    doAccess(32'h2000, 1'b0, 1'b1, 2'd2, {23'h0, 4'd9, 5'b0}, '0, "R2");

    // R3/R4: every domain value on sections and page tables, domain 5
    for (int dv = 0; dv < 4; dv++) begin
      domainCtl = 32'h0 | (dv << 10);
      doAccess(32'h3000, 1'b1, 1'b0, 2'd2, secDesc(4'd5, 2'b00), '0, "R3_R4_sec");
      doAccess(32'h3000, 1'b1, 1'b0, 2'd2, tblDesc(4'd5),
               pgDesc(2'b10, 8'h00), "R3_R4_page");
    end

    // R5/R8: client section, full permission sweep in domain 2
    domainCtl = 32'h0000_0010;
    for (int sr = 0; sr < 4; sr++) begin
      sysProt = sr[1]; romProt = sr[0];
      for (int ap = 0; ap < 4; ap++)
        for (int m = 0; m < 4; m++)
          doAccess(32'h4000, m[0], m[1], 2'd0, secDesc(4'd2, ap[1:0]), '0, "R5_R8");
    end
    sysProt = 1'b0; romProt = 1'b0;

    // R7: quarter selection, fields ap3..ap0 = 11,10,01,00, user write in domain 7
    domainCtl = 32'h0000_4000;
    for (int q = 0; q < 4; q++) begin
      doAccess({16'h0, q[1:0], 2'b00, ~q[1:0], 10'h0}, 1'b1, 1'b0, 2'd2,
               tblDesc(4'd7), pgDesc(2'b01, 8'b11100100), "R7_large");
      doAccess({16'h0, ~q[1:0], 2'b00, q[1:0], 10'h0}, 1'b1, 1'b0, 2'd2,
               tblDesc(4'd7), pgDesc(2'b10, 8'b11100100), "R7_small");
      doAccess({16'h0, q[1:0], 2'b00, q[1:0], 10'h0}, 1'b0, 1'b0, 2'd2,
               tblDesc(4'd7), pgDesc(2'b10, 8'b00011011), "R7_small_read");
    end
    doAccess(32'h0000_FC00, 1'b0, 1'b0, 2'd2, tblDesc(4'd7),
             pgDesc(2'b11, 8'b11111101), "R7_tiny");
    doAccess(32'h0000_FC00, 1'b0, 1'b0, 2'd2, tblDesc(4'd7),
             pgDesc(2'b11, 8'b00000010), "R7_tiny");

    // R6: invalid second level under client and manager
    doAccess(32'h5000, 1'b0, 1'b1, 2'd2, tblDesc(4'd7), pgDesc(2'b00, 8'hFF), "R6");
    domainCtl = 32'h0000_C000;
    doAccess(32'h5000, 1'b0, 1'b1, 2'd2, tblDesc(4'd7), pgDesc(2'b00, 8'hFF), "R6");
    doAccess(32'h5000, 1'b1, 1'b0, 2'd2, tblDesc(4'd7), pgDesc(2'b01, 8'h00), "R4");

    // R10: requests while waiting for the first level are dropped
    domainCtl = 32'h0000_0003;
    expQ.push_back('{1'b0, 4'h0, 4'h0, "R10"});
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h6000; reqSize = 2'd2; reqWrite = 1'b0; reqPriv = 1'b0;
    @(negedge clk);
    reqAddr = 32'h6001;  // misaligned, must be ignored
    @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    l1Valid = 1'b1; l1Desc = secDesc(4'd0, 2'b00);
    @(negedge clk);
    l1Valid = 1'b0;
    repeat (3) @(negedge clk);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R9 results missing: actual %0d pending expected 0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule